// File: doc/BRIEF.md
# Input change interrupt detector

This block watches a set of input pins, organised as banks of eight, and raises an interrupt flag while any pin that is configured as an input sits at a level different from a stored reference copy of that pin. The flag is a level, not a latched event. It is recomputed from a continuous comparison and registered by one flop. If a pin that changed goes back to its stored level, the flag drops again without any software action.

Each bank keeps its own reference copy, called the snapshot. A bank's snapshot is reloaded from the live pin levels in three cases: the register interface reads that bank's input register, the configuration register is written, or the block is in reset. When the flag clears after a read, it clears only because the snapshot now matches the pins. The pins arrive already synchronised. Register decode and the pin driver sit outside this block.

Top module: `chg_irq_detect`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `irq_flag` is 0. The snapshot holds the pin levels present at the last reset edge, so pins that do not move after reset never raise the flag.
- R2: A pin whose direction bit is 0 (output) has no effect on `irq_flag`, whatever its level.
- R3: If an input pin (direction bit 1) differs from its snapshot bit at a clock edge, `irq_flag` is 1 after that edge. It stays 1 for as long as the mismatch persists and no sample refreshes that bank.
- R4: When every mismatching pin returns to its snapshot level, `irq_flag` returns to 0 on the next edge, with no read and no configuration write needed.
- R5: A pulse on `bank_rd[b]` loads bank b's snapshot (bank b covers pins 8*b+7 down to 8*b) from the pins at that edge. `irq_flag` after that edge carries no mismatch from bank b.
- R6: A pulse on `bank_rd[b]` leaves the snapshot of every other bank unchanged, so a mismatch in another bank keeps `irq_flag` at 1.
- R7: A pulse on `cfg_wr` loads every bank's snapshot at that edge, and `irq_flag` is 0 after that edge.
- R8: Changing a pin's direction bit from 0 to 1 while its level differs from its snapshot raises `irq_flag` on the next edge. This spurious interrupt is intended behaviour and is not masked.
- R9: When a pin changes at the same edge as a sample pulse for its bank, the new level is the one stored, and `irq_flag` stays 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; snapshots track the pins while low |
| pin_lvl | input | 16 | Synchronised pin levels, bit i is pin i |
| dir_in | input | 16 | Direction per pin, 1 = input (monitored), 0 = output |
| bank_rd | input | 2 | One-cycle pulse per bank: input register of that bank is read |
| cfg_wr | input | 1 | One-cycle pulse: configuration register written |
| irq_flag | output | 1 | Registered interrupt flag, 1 while a monitored pin mismatches |

## Verification
Two functions can meet on the same edge: a pin changing level and the sample pulse that refreshes the bank holding that pin. The bench moves a pin and pulses the read or configuration-write line at the same falling edge. It then expects the flag to stay low, because the stored level must be the new one. In the other case, a bank read meets a change in the other bank, and the flag must rise. A behavioural reference model that keeps per-pin snapshots as integers is compared with the flag on every cycle. This covers directed cases and a long pseudo-random stretch that mixes pin, direction and pulse activity.

// File: rtl/cid_pkg.sv
// Package: shared sizing constants for the input change interrupt detector.
// Assumes every bank has the same width; the pin count is the product.
package cid_pkg;
    localparam int CID_BANK_W  = 8;
    localparam int CID_N_BANKS = 2;
    localparam int CID_PIN_W   = CID_BANK_W * CID_N_BANKS;
endpackage

// File: rtl/cid_bank_snap.sv
// Module: cid_bank_snap
// Holds one bank's snapshot of the pin levels. Outputs the reference level
// that applies at the current edge: the live pins when a sample is taken now,
// otherwise the stored snapshot. Assumes pins are already synchronised.
module cid_bank_snap #(
    parameter int BANK_W = cid_pkg::CID_BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [BANK_W-1:0] pins,
    output logic [BANK_W-1:0] ref_lvl
);
    logic [BANK_W-1:0] snap_q;

    // Snapshot register: track pins during reset, reload on sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= pins;
        end else if (sample) begin
            snap_q <= pins;
        end
    end

    // Reference seen by the comparator: a sample this cycle means match.
    always_comb begin
        ref_lvl = sample ? pins : snap_q;
    end
endmodule

// File: rtl/cid_bank_cmp.sv
// Module: cid_bank_cmp
// Compares one bank's pins against its reference and reports whether any
// pin configured as input (direction bit 1) mismatches. Purely combinational.
module cid_bank_cmp #(
    parameter int BANK_W = cid_pkg::CID_BANK_W
) (
    input  logic [BANK_W-1:0] pins,
    input  logic [BANK_W-1:0] ref_lvl,
    input  logic [BANK_W-1:0] dir,
    output logic              hit
);
    logic [BANK_W-1:0] diff;

    // Per-pin mismatch masked by direction, reduced to one bank hit.
    always_comb begin
        diff = (pins ^ ref_lvl) & dir;
        hit  = |diff;
    end
endmodule

// File: rtl/cid_flag_reg.sv
// Module: cid_flag_reg
// Combines the per-bank hits into the interrupt level and registers it.
// Assumes the hits are valid before the clock edge; reset clears the flag.
module cid_flag_reg #(
    parameter int N_BANKS = cid_pkg::CID_N_BANKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_BANKS-1:0] bank_hit,
    output logic               flag
);
    logic any_hit;

    // OR of all bank hits.
    always_comb begin
        any_hit = |bank_hit;
    end

    // Single output flop for the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= any_hit;
        end
    end
endmodule

// File: rtl/chg_irq_detect.sv
// Module: chg_irq_detect (top)
// Raises irq_flag while any input-direction pin differs from its bank's
// snapshot. Snapshots reload on a bank read, on a configuration write, and
// while in reset. Assumes pin_lvl is synchronised and pulses last one cycle.
module chg_irq_detect #(
    parameter int BANK_W  = cid_pkg::CID_BANK_W,
    parameter int N_BANKS = cid_pkg::CID_N_BANKS,
    localparam int PIN_W  = BANK_W * N_BANKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIN_W-1:0]   pin_lvl,
    input  logic [PIN_W-1:0]   dir_in,
    input  logic [N_BANKS-1:0] bank_rd,
    input  logic               cfg_wr,
    output logic               irq_flag
);
    logic [N_BANKS-1:0] bank_hit;
    logic [N_BANKS-1:0] bank_sample;

    // Per-bank snapshot and comparison slice.
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] ref_lvl;

        // A bank samples on its own read or on any configuration write.
        always_comb begin
            bank_sample[b] = bank_rd[b] | cfg_wr;
        end

        cid_bank_snap #(.BANK_W(BANK_W)) u_snap (
            .clk     (clk),
            .rst_n   (rst_n),
            .sample  (bank_sample[b]),
            .pins    (pin_lvl[b*BANK_W +: BANK_W]),
            .ref_lvl (ref_lvl)
        );

        cid_bank_cmp #(.BANK_W(BANK_W)) u_cmp (
            .pins    (pin_lvl[b*BANK_W +: BANK_W]),
            .ref_lvl (ref_lvl),
            .dir     (dir_in[b*BANK_W +: BANK_W]),
            .hit     (bank_hit[b])
        );
    end

    cid_flag_reg #(.N_BANKS(N_BANKS)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_hit (bank_hit),
        .flag     (irq_flag)
    );
endmodule

// File: rtl/chg_irq_detect_chk.sv
// Module: chg_irq_detect_chk
// Port-level properties of the detector, bound to every instance of the top.
module chg_irq_detect_chk #(
    parameter int BANK_W  = cid_pkg::CID_BANK_W,
    parameter int N_BANKS = cid_pkg::CID_N_BANKS,
    localparam int PIN_W  = BANK_W * N_BANKS
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PIN_W-1:0]   pin_lvl,
    input logic [PIN_W-1:0]   dir_in,
    input logic [N_BANKS-1:0] bank_rd,
    input logic               cfg_wr,
    input logic               irq_flag
);
    // R1: flag is low on the first cycle out of reset.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_flag);

    // R2: no monitored pins at the previous edge means no flag now.
    assert_outputs_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dir_in) == '0) |-> !irq_flag);

    // R3: a standing mismatch with nothing changing keeps the flag up.
    assert_flag_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && $stable(pin_lvl) && $stable(dir_in) && bank_rd == '0 && !cfg_wr)
        |=> irq_flag);

    // R5: reading every bank at once leaves nothing to compare against.
    assert_all_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd == '1) |=> !irq_flag);

    // R7: a configuration write refreshes all snapshots.
    assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !irq_flag);
endmodule

bind chg_irq_detect chg_irq_detect_chk #(.BANK_W(BANK_W), .N_BANKS(N_BANKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .dir_in   (dir_in),
    .bank_rd  (bank_rd),
    .cfg_wr   (cfg_wr),
    .irq_flag (irq_flag)
);

// File: tb/chg_irq_detect_bench.sv
// Bench for chg_irq_detect: directed cases plus a pseudo-random stretch,
// with a behavioural reference model compared on every falling edge.
module chg_irq_detect_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_lvl = 16'hA5C3;
    logic [15:0] dir_in = 16'hFFFF;
    logic [1:0]  bank_rd = 2'b00;
    logic        cfg_wr = 1'b0;
    logic        irq_flag;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Reference model state: one integer per pin snapshot, plus the flag.
    int m_snap [16];
    bit m_flag = 1'b0;

    chg_irq_detect u_chg_irq_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_lvl),
        .dir_in   (dir_in),
        .bank_rd  (bank_rd),
        .cfg_wr   (cfg_wr),
        .irq_flag (irq_flag)
    );

    always #2 clk = ~clk;

    // Reference model, evaluated at each rising edge from the requirements.
    always @(posedge clk) begin
        bit any;
        any = 1'b0;
        for (int i = 0; i < 16; i++) begin
            bit smp;
            smp = !rst_n || cfg_wr || bank_rd[i / 8];
            if (smp) m_snap[i] = int'(pin_lvl[i]);
            if (rst_n && dir_in[i] && (int'(pin_lvl[i]) != m_snap[i])) any = 1'b1;
        end
        m_flag = rst_n ? any : 1'b0;
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (irq_flag !== m_flag) begin
                n_fail++;
                $display("FAIL %s model compare at %0t: irq_flag=%b expected=%b",
                         cur_req, $time, irq_flag, m_flag);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input bit exp);
        n_checks++;
        if (irq_flag !== exp) begin
            n_fail++;
            $display("FAIL %s directed at %0t: irq_flag=%b expected=%b",
                     req, $time, irq_flag, exp);
        end
    endtask

    task automatic pulse_rd(input logic [1:0] which);
        bank_rd = which;
        step(1);
        bank_rd = 2'b00;
    endtask

    task automatic pulse_cfg();
        cfg_wr = 1'b1;
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 16; i++) m_snap[i] = 0;
        step(1);
        check("R1", 1'b0);
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1", 1'b0);
        step(2);
        check("R1", 1'b0);

        // R2: upper bank as outputs; moving an output pin does nothing.
        cur_req = "R2";
        dir_in = 16'h00FF;
        pin_lvl[12] = ~pin_lvl[12];
        step(1);
        check("R2", 1'b0);
        pin_lvl[12] = ~pin_lvl[12];
        dir_in = 16'hFFFF;
        step(1);
        check("R2", 1'b0);

        // R3: an input pin moves, flag rises and holds.
        cur_req = "R3";
        pin_lvl[3] = ~pin_lvl[3];
        step(1);
        check("R3", 1'b1);
        step(3);
        check("R3", 1'b1);

        // R4: pin returns, flag drops without a read.
        cur_req = "R4";
        pin_lvl[3] = ~pin_lvl[3];
        step(1);
        check("R4", 1'b0);

        // R5: read bank 0 after a bank-0 change clears the flag.
        cur_req = "R5";
        pin_lvl[2] = ~pin_lvl[2];
        step(1);
        check("R5", 1'b1);
        pulse_rd(2'b01);
        check("R5", 1'b0);
        step(2);
        check("R5", 1'b0);

        // R6: a bank-0 read leaves a bank-1 mismatch standing.
        cur_req = "R6";
        pin_lvl[10] = ~pin_lvl[10];
        step(1);
        check("R6", 1'b1);
        pulse_rd(2'b01);
        check("R6", 1'b1);
        step(1);
        check("R6", 1'b1);
        pulse_rd(2'b10);
        check("R6", 1'b0);

        // R7: changes in both banks, a configuration write clears them.
        cur_req = "R7";
        pin_lvl = pin_lvl ^ 16'h0810;
        step(1);
        check("R7", 1'b1);
        pulse_cfg();
        check("R7", 1'b0);
        step(2);
        check("R7", 1'b0);

        // R8: output pin moved, then turned into an input: spurious flag.
        cur_req = "R8";
        dir_in[5] = 1'b0;
        pin_lvl[5] = ~pin_lvl[5];
        step(1);
        check("R8", 1'b0);
        dir_in[5] = 1'b1;
        step(1);
        check("R8", 1'b1);
        pulse_cfg();
        check("R8", 1'b0);

        // R9: change and sample on the same edge, for each sample source.
        cur_req = "R9";
        pin_lvl[1] = ~pin_lvl[1];
        pulse_rd(2'b01);
        check("R9", 1'b0);
        pin_lvl[14] = ~pin_lvl[14];
        pulse_rd(2'b10);
        check("R9", 1'b0);
        pin_lvl = pin_lvl ^ 16'h4242;
        pulse_cfg();
        check("R9", 1'b0);
        pin_lvl[9] = ~pin_lvl[9];
        pulse_rd(2'b01);
        check("R9", 1'b1);
        pulse_rd(2'b10);
        check("R9", 1'b0);

        // R3: pseudo-random mix, judged by the per-cycle model compare.
        cur_req = "R3";
        lfsr = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) pin_lvl[lfsr[7:4]] = ~pin_lvl[lfsr[7:4]];
            if (lfsr[3:1] == 3'b000) dir_in[lfsr[11:8]] = ~dir_in[lfsr[11:8]];
            bank_rd = (lfsr[15:13] == 3'b000) ? lfsr[2:1] : 2'b00;
            cfg_wr = (lfsr[15:11] == 5'b11111);
            step(1);
        end
        bank_rd = 2'b00;
        cfg_wr = 1'b0;
        step(2);
        finish_run();
    end
endmodule